// File: doc/BRIEF.md
# Seven-to-One Pixel Serializer

This block turns a 35-bit parallel pixel word into five serial data lanes and one forwarded-clock lane. One word is taken per pixel clock period. The word is split into five groups of seven bits, and each group is shifted out on its own lane at seven times the pixel rate. A bit clock at seven times the pixel frequency, phase-aligned to the pixel clock, drives the serial side.

Either pixel clock edge can capture the word, chosen by a static select input. The serial side finds the rising edge of the pixel clock and uses it to align a seven-slot counter. Captured words move through a two-entry holding register and then a staging register. They are loaded into the lane shift registers only when the slot counter wraps, so a frame always carries one whole word. The forwarded-clock lane sends a fixed seven-slot waveform. Every lane sees the same three-pixel-period latency, so data stays aligned with the clock lane.

A controller decides when the outputs are driven. Its states are:
- ST_OFF: power-down is active.
- ST_LOCKWAIT: waiting for the PLL lock input.
- ST_ALIGN: waiting for a pixel-clock edge to align the slot counter.
- ST_FILL: waiting three frame wraps while the pipeline fills.
- ST_RUN: outputs enabled.

Its transitions are:
- power-down low in any state goes to ST_OFF.
- ST_OFF goes to ST_LOCKWAIT when power-down is released.
- ST_LOCKWAIT goes to ST_ALIGN on lock.
- ST_ALIGN goes to ST_FILL when a pixel edge is seen.
- ST_FILL goes to ST_RUN on the third wrap.
- ST_ALIGN, ST_FILL and ST_RUN go to ST_LOCKWAIT on loss of lock.

The pad output enable is high only in ST_RUN.

Top module: `pixel_serializer`

## Requirements
- R1: While reset is asserted, out_en, every bit of lane_out and clk_lane_out are 0.
- R2: Lane l (l = 0..4) carries din[7l+6:7l]. Within a frame, slot k (k = 0..6, slot 0 beginning at the bit clock edge where the pixel clock rises) sends bit 6-k of that group, most significant first.
- R3: A word captured in pixel period p is sent in the frame that starts at the rising pixel clock edge that opens period p+3.
- R4: With edge_rise_sel = 1, the word is the value of din at the rising pixel clock edge.
- R5: With edge_rise_sel = 0, the word is the value of din at the falling pixel clock edge.
- R6: While out_en is high, clk_lane_out sends 1,1,0,0,0,1,1 in slots 0 to 6 of every frame.
- R7: When pd_n is sampled low on a bit clock edge, out_en is 0 from that edge on. This holds even when that edge is a frame wrap.
- R8: After power-down is released, out_en and clk_lane_out stay 0 for as long as lock is low.
- R9: Once lock is high, out_en rises within 60 bit clock cycles. It rises at the start of slot 0, with the clock lane high in that slot.
- R10: When lock is sampled low, out_en is 0 from that edge on.
- R11: While out_en is 0, every bit of lane_out and clk_lane_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock, seven times the pixel clock, phase-aligned |
| rst_n | input | 1 | Asynchronous active-low reset, bit clock domain |
| pclk | input | 1 | Pixel clock |
| pd_n | input | 1 | Active-low power-down |
| lock | input | 1 | PLL lock indication |
| edge_rise_sel | input | 1 | 1: capture on rising pixel edge, 0: on falling edge |
| din | input | 35 | Parallel pixel word, five groups of seven bits |
| lane_out | output | 5 | Serial data lanes, one bit per lane per slot |
| clk_lane_out | output | 1 | Forwarded-clock lane |
| out_en | output | 1 | Output enable for the tri-state pad drivers |

## Verification
Two actions can land on the same bit clock edge: a power-down request and the frame wrap that reloads every shift register. The bench drops pd_n in slot 6 so that it is sampled exactly on the wrap edge. It then expects out_en low and every lane quiet in the next slot, with no stray first bit of the new frame. After release, the link must come back at a slot-0 boundary with correct words. The same check is repeated with power-down in mid-frame and with loss of lock. Around these events, thousands of slot-by-slot comparisons under both capture edges use words computed arithmetically from the period number.

// File: rtl/pixel_serializer_pkg.sv
package pixel_serializer_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_LOCKWAIT,
        ST_ALIGN,
        ST_FILL,
        ST_RUN
    } link_state_t;

    // Forwarded-clock frame, MSB sent first: two high slots at each end.
    function automatic logic [31:0] fwd_clk_pattern(input int slots);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < slots; k++) begin
            if (k < 2 || k >= slots - 2) begin
                r[slots-1-k] = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pixel_capture.sv
module pixel_capture #(
    parameter int WIDTH = 35
) (
    input  logic             pclk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cap_rise,
    output logic [WIDTH-1:0] cap_fall
);

    // Both edges are always sampled; the serial side picks one.
    always_ff @(posedge pclk) begin
        cap_rise <= din;
    end

    always_ff @(negedge pclk) begin
        cap_fall <= din;
    end

endmodule

// File: rtl/slot_tracker.sv
module slot_tracker #(
    parameter int SLOTS = 7
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic pclk,
    output logic edge_seen,
    output logic wrap,
    output logic copy_now
);

    localparam int SW = $clog2(SLOTS);
    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);
    localparam logic [SW-1:0] COPY_SLOT = SW'(SLOTS - 2);

    logic          pclk_q;
    logic [SW-1:0] slot;

    // The pixel clock is phase-aligned to the bit clock, so its level is
    // sampled directly; the edge shows one bit period after it occurs.
    assign edge_seen = pclk & ~pclk_q;
    assign wrap      = (slot == LAST_SLOT);
    assign copy_now  = (slot == COPY_SLOT);

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            pclk_q <= 1'b0;
            slot   <= '0;
        end else begin
            pclk_q <= pclk;
            if (edge_seen) begin
                slot <= SW'(1);
            end else if (wrap) begin
                slot <= '0;
            end else begin
                slot <= slot + SW'(1);
            end
        end
    end

endmodule

// File: rtl/lane_pipeline.sv
module lane_pipeline
    import pixel_serializer_pkg::*;
#(
    parameter int LANES = 5,
    parameter int SLOTS = 7
) (
    input  logic                   bclk,
    input  logic                   rst_n,
    input  logic                   copy_now,
    input  logic                   wrap,
    input  logic                   edge_rise_sel,
    input  logic [LANES*SLOTS-1:0] cap_rise,
    input  logic [LANES*SLOTS-1:0] cap_fall,
    output logic [LANES-1:0]       lane_msb,
    output logic                   clk_msb
);

    localparam int W = LANES * SLOTS;
    localparam logic [SLOTS-1:0] CLK_PAT = SLOTS'(fwd_clk_pattern(SLOTS));

    logic [W-1:0] hold [2];
    logic         wr_ptr;
    logic [W-1:0] stage;
    logic [SLOTS-1:0] clk_sh;

    // Two-entry holding register: the entry read at wrap is always the
    // older one, so a write never lands on the word being read.
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            hold[0] <= '0;
            hold[1] <= '0;
            wr_ptr  <= 1'b0;
            stage   <= '0;
        end else begin
            if (copy_now) begin
                hold[wr_ptr] <= edge_rise_sel ? cap_rise : cap_fall;
                wr_ptr       <= ~wr_ptr;
            end
            if (wrap) begin
                stage <= hold[wr_ptr];
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SLOTS-1:0] sh;
        always_ff @(posedge bclk or negedge rst_n) begin
            if (!rst_n) begin
                sh <= '0;
            end else if (wrap) begin
                sh <= stage[l*SLOTS +: SLOTS];
            end else begin
                sh <= {sh[SLOTS-2:0], 1'b0};
            end
        end
        assign lane_msb[l] = sh[SLOTS-1];
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sh <= '0;
        end else if (wrap) begin
            clk_sh <= CLK_PAT;
        end else begin
            clk_sh <= {clk_sh[SLOTS-2:0], clk_sh[SLOTS-1]};
        end
    end

    assign clk_msb = clk_sh[SLOTS-1];

endmodule

// File: rtl/link_ctrl.sv
module link_ctrl
    import pixel_serializer_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic lock,
    input  logic edge_seen,
    input  logic wrap,
    output logic run
);

    localparam int CW = $clog2(LATENCY + 1);
    localparam logic [CW-1:0] FILL_LAST = CW'(LATENCY - 1);

    link_state_t state;
    link_state_t nxt;
    logic [CW-1:0] fill_cnt;

    // State register and fill counter.
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            fill_cnt <= '0;
        end else begin
            state <= nxt;
            if (state != ST_FILL) begin
                fill_cnt <= '0;
            end else if (wrap) begin
                fill_cnt <= fill_cnt + CW'(1);
            end
        end
    end

    always_comb begin
        nxt = state;
        if (!pd_n) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:      nxt = ST_LOCKWAIT;
                ST_LOCKWAIT: if (lock) nxt = ST_ALIGN;
                ST_ALIGN: begin
                    if (!lock)          nxt = ST_LOCKWAIT;
                    else if (edge_seen) nxt = ST_FILL;
                end
                ST_FILL: begin
                    if (!lock)                               nxt = ST_LOCKWAIT;
                    else if (wrap && fill_cnt == FILL_LAST)  nxt = ST_RUN;
                end
                ST_RUN:      if (!lock) nxt = ST_LOCKWAIT;
                default:     nxt = ST_OFF;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        run = (state == ST_RUN);
    end

endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer #(
    parameter int LANES   = 5,
    parameter int SLOTS   = 7,
    parameter int LATENCY = 3
) (
    input  logic                   bclk,
    input  logic                   rst_n,
    input  logic                   pclk,
    input  logic                   pd_n,
    input  logic                   lock,
    input  logic                   edge_rise_sel,
    input  logic [LANES*SLOTS-1:0] din,
    output logic [LANES-1:0]       lane_out,
    output logic                   clk_lane_out,
    output logic                   out_en
);

    localparam int W = LANES * SLOTS;

    logic [W-1:0]     cap_rise;
    logic [W-1:0]     cap_fall;
    logic             edge_seen;
    logic             wrap;
    logic             copy_now;
    logic [LANES-1:0] lane_msb;
    logic             clk_msb;
    logic             run;

    pixel_capture #(.WIDTH(W)) u_capture (
        .pclk     (pclk),
        .din      (din),
        .cap_rise (cap_rise),
        .cap_fall (cap_fall)
    );

    slot_tracker #(.SLOTS(SLOTS)) u_slots (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .pclk      (pclk),
        .edge_seen (edge_seen),
        .wrap      (wrap),
        .copy_now  (copy_now)
    );

    lane_pipeline #(.LANES(LANES), .SLOTS(SLOTS)) u_pipe (
        .bclk          (bclk),
        .rst_n         (rst_n),
        .copy_now      (copy_now),
        .wrap          (wrap),
        .edge_rise_sel (edge_rise_sel),
        .cap_rise      (cap_rise),
        .cap_fall      (cap_fall),
        .lane_msb      (lane_msb),
        .clk_msb       (clk_msb)
    );

    link_ctrl #(.LATENCY(LATENCY)) u_ctrl (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .pd_n      (pd_n),
        .lock      (lock),
        .edge_seen (edge_seen),
        .wrap      (wrap),
        .run       (run)
    );

    assign out_en       = run;
    assign lane_out     = run ? lane_msb : '0;
    assign clk_lane_out = run & clk_msb;

endmodule

// File: rtl/pixel_serializer_chk.sv
module pixel_serializer_chk #(
    parameter int LANES = 5
) (
    input logic             bclk,
    input logic             rst_n,
    input logic             pd_n,
    input logic             lock,
    input logic             out_en,
    input logic [LANES-1:0] lane_out,
    input logic             clk_lane_out
);

    // R7
    pd_quiet_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        !pd_n |=> !out_en);

    // R10
    lock_loss_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        !lock |=> !out_en);

    // R11
    idle_lanes_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        !out_en |-> (lane_out == '0 && !clk_lane_out));

    // R9
    enable_frame_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        $rose(out_en) |-> clk_lane_out);

    // R6
    clk_high_pair_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        (out_en && $past(out_en) && $rose(clk_lane_out)) |=> (clk_lane_out || !out_en));

endmodule

bind pixel_serializer pixel_serializer_chk #(.LANES(LANES)) u_pixel_serializer_chk (
    .bclk         (bclk),
    .rst_n        (rst_n),
    .pd_n         (pd_n),
    .lock         (lock),
    .out_en       (out_en),
    .lane_out     (lane_out),
    .clk_lane_out (clk_lane_out)
);

// File: tb/test_pixel_serializer.sv
module test_pixel_serializer;

    localparam int LANES = 5;
    localparam int SLOTS = 7;
    localparam logic [6:0] PAT = 7'b1100011;

    logic        bclk = 1'b0;
    logic        pclk = 1'b0;
    logic        rst_n, pd_n, lock, sel;
    logic [34:0] din;
    logic [4:0]  lane_out;
    logic        clk_lane_out, out_en;

    int ph = 6;
    int pc = -1;
    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit data_chk = 0;

    always #10 bclk = ~bclk;

    // Pixel clock: rises with the bit clock edge opening slot 0, high three slots.
    always @(posedge bclk) begin
        ph   <= (ph == 6) ? 0 : ph + 1;
        pclk <= (ph == 6) || (ph < 2);
        if (ph == 6) pc <= pc + 1;
    end

    pixel_serializer i_pixel_serializer (
        .bclk(bclk), .rst_n(rst_n), .pclk(pclk), .pd_n(pd_n), .lock(lock),
        .edge_rise_sel(sel), .din(din), .lane_out(lane_out),
        .clk_lane_out(clk_lane_out), .out_en(out_en)
    );

    function automatic logic [34:0] wa(input int p);
        logic [63:0] x;
        x = 64'(p) * 64'h9E37_79B9_7F4A_7C15;
        return x[63:29] ^ (35'd1 << (p % 35));
    endfunction

    function automatic logic [34:0] wb(input int p);
        logic [63:0] x;
        x = 64'(p + 1000) * 64'hC2B2_AE3D_27D4_EB4F;
        return x[40:6];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h (period %0d slot %0d)", req, act, exp, pc, ph);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Drive din: falling-edge word in slot 1, next rising-edge word in slot 5.
    initial din = wa(0);
    always @(negedge bclk) begin
        if (ph == 1)      din <= wb(pc);
        else if (ph == 5) din <= wa(pc + 1);
    end

    // Slot-by-slot stream check (R2 R3 R4 R5 R6).
    always @(negedge bclk) begin
        logic [34:0] w;
        logic [4:0]  e;
        if (data_chk && rst_n) begin
            w = sel ? wa(pc - 3) : wb(pc - 3);
            for (int l = 0; l < LANES; l++) e[l] = w[l*SLOTS + 6 - ph];
            chk(out_en == 1'b1, "R9 enable held", 64'(out_en), 64'd1);
            chk(lane_out == e, sel ? "R2 R3 R4" : "R2 R3 R5", 64'(lane_out), 64'(e));
            chk(clk_lane_out == PAT[6-ph], "R6", 64'(clk_lane_out), 64'(PAT[6-ph]));
        end
    end

    always @(posedge bclk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            n_err++;
            $display("FAIL R9 watchdog: actual %0d cycles expected fewer", cyc);
            report();
        end
    end

    task automatic wait_ph(input int k);
        do @(negedge bclk); while (ph != k);
    endtask

    task automatic run_periods(input int n);
        repeat (n * SLOTS) @(negedge bclk);
    endtask

    task automatic quiet(input int n, input string req);
        repeat (n) begin
            @(negedge bclk);
            chk(!out_en && lane_out == '0 && !clk_lane_out, req,
                64'({out_en, lane_out, clk_lane_out}), 64'd0);
        end
    endtask

    task automatic wait_enable();
        bit found;
        data_chk = 0;
        found = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge bclk);
            if (out_en) begin
                found = 1;
                break;
            end
        end
        chk(found, "R9 enable after lock", 64'(found), 64'd1);
        chk(ph == 0, "R9 slot 0 start", 64'(ph), 64'd0);
        chk(clk_lane_out == 1'b1, "R9 R6 first slot", 64'(clk_lane_out), 64'd1);
        data_chk = 1;
    endtask

    initial begin
        rst_n = 0; pd_n = 0; lock = 0; sel = 1;
        repeat (4) @(negedge bclk);
        chk(!out_en && lane_out == '0 && !clk_lane_out, "R1",
            64'({out_en, lane_out, clk_lane_out}), 64'd0);
        rst_n = 1;
        quiet(5, "R7 R11 powered down");
        pd_n = 1;
        quiet(20, "R8 R11 waiting lock");

        lock = 1;
        wait_enable();
        run_periods(30);

        data_chk = 0; sel = 0; run_periods(5);
        data_chk = 1; run_periods(30);

        // Power-down sampled on the frame wrap edge.
        data_chk = 0;
        wait_ph(6);
        pd_n = 0;
        quiet(1, "R7 on wrap");
        quiet(10, "R11 after power-down");
        pd_n = 1;
        wait_enable();
        run_periods(20);

        data_chk = 0; sel = 1; run_periods(5);
        data_chk = 1; run_periods(20);

        // Power-down in mid-frame.
        data_chk = 0;
        wait_ph(3);
        pd_n = 0;
        quiet(1, "R7 mid-frame");
        pd_n = 1;
        wait_enable();
        run_periods(10);

        // Loss of lock.
        data_chk = 0;
        wait_ph(2);
        lock = 0;
        quiet(1, "R10");
        quiet(10, "R8 R11 lock lost");
        lock = 1;
        wait_enable();
        run_periods(10);

        data_chk = 0;
        report();
    end

endmodule